// File: doc/BRIEF.md
# Decode-Stage Branch Redirect and Fetch Unit

This block owns the program counter and the fetch/decode pipeline register of a five-stage in-order pipeline. Conditional branches are resolved in the decode stage. The condition is a test of one register operand against zero, and a dedicated adder forms the taken target there. Because of this, the instruction fetched while a branch sits in decode (its delay slot) always enters the pipeline, and the redirect takes effect on the fetch that follows it.

Two flavours of branch are supported. An ordinary delayed branch always lets its slot execute. A "likely" branch lets its slot run only when taken, and turns the slot into a bubble when not taken. The decoder, the register file and the instruction memory sit outside the block. The decoder returns the branch kind, the operand value and the sign-extended word offset for whatever instruction the block presents at its decode outputs.

A stall input freezes the counter and the fetch/decode register. A branch held in decode keeps its decision pending across the stall.

Top module: `fetch_redirect`

## Requirements
- R1: While reset is asserted, the fetch address equals RESET_PC (default 0), `id_valid_o` is 0, and `redirect_o` and `squash_o` are 0.
- R2: Without a redirect or stall, the fetch address advances by 4 each clock. The fetch/decode register captures the fetched word and its address, which appear on `id_instr_o` and `id_pc_o` one clock later.
- R3: Branch kind encoding on `dec_br_kind_i`:
  - 0 is not a branch.
  - 1 is taken when the operand equals zero.
  - 2 is taken when the operand is non-zero.
  - 3 is the likely form of 1.
  - 4 is the likely form of 2.
  - Codes 5 to 7 behave as not a branch.
- R4: The condition is evaluated in the same cycle the branch is in decode, and `redirect_o` shows the taken decision in that cycle.
- R5: The taken target is the address being fetched while the branch is in decode (the slot address) plus the offset shifted left by 2. The target is fetched on the clock right after the slot is fetched.
- R6: For kinds 1 and 2, and for a taken kind 3 or 4, the slot instruction enters decode as valid.
- R7: A not-taken kind 3 or 4 raises `squash_o`. The slot then enters decode with `id_valid_o` at 0, and `id_reg_we_o` and `id_mem_we_o` forced to 0.
- R8: While `stall_i` is 1, the fetch address and the decode outputs hold. A taken branch held in decode redirects fetch once the stall is released.
- R9: Branch fields presented while decode holds no valid instruction (such as a squashed slot) have no effect on fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Freeze fetch and the fetch/decode register |
| imem_addr_o | output | XLEN | Address of the instruction being fetched |
| imem_data_i | input | IW | Instruction word at `imem_addr_o` |
| id_valid_o | output | 1 | Decode stage holds a live instruction |
| id_pc_o | output | XLEN | Address of the instruction in decode |
| id_instr_o | output | IW | Instruction word in decode |
| dec_br_kind_i | input | 3 | Branch kind decoded from `id_instr_o` |
| dec_rs_i | input | XLEN | Register operand tested against zero |
| dec_offset_i | input | XLEN | Sign-extended word offset |
| dec_reg_we_i | input | 1 | Decoded register-write enable |
| dec_mem_we_i | input | 1 | Decoded memory-write enable |
| id_reg_we_o | output | 1 | Register-write enable passed on, zero for bubbles |
| id_mem_we_o | output | 1 | Memory-write enable passed on, zero for bubbles |
| redirect_o | output | 1 | Branch in decode is taken |
| squash_o | output | 1 | Slot now in fetch is annulled |
| next_pc_o | output | XLEN | Fetch address for the next clock |

## Verification
Each test places one branch at a chosen address and runs from reset.

- **Operand and kind coverage.** Zero and non-zero operands are applied to both test senses. This separates a swapped condition from a correct one.
- **Target arithmetic.** A backward (negative) offset is used alongside forward ones. This exposes a target adder that drops the sign or the shift.
- **Likely forms.** The likely forms are run both taken and not taken. This distinguishes annulling from always annulling or never annulling.
- **Stall, undefined kinds and squashed-slot fields.** A stall held over a taken branch shows whether the redirect survives. Undefined kind codes must behave as plain instructions. Branch fields on a squashed slot must be ignored.

// File: rtl/fetch_redirect_pkg.sv
package fetch_redirect_pkg;
  typedef logic [2:0] br_kind_t;
  localparam br_kind_t BK_NONE    = 3'd0;
  localparam br_kind_t BK_EQZ     = 3'd1;
  localparam br_kind_t BK_NEZ     = 3'd2;
  localparam br_kind_t BK_EQZ_LK  = 3'd3;
  localparam br_kind_t BK_NEZ_LK  = 3'd4;
endpackage

// File: rtl/br_resolve.sv
module br_resolve
  import fetch_redirect_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            valid_i,
  input  br_kind_t        kind_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] offset_i,
  input  logic [XLEN-1:0] slot_pc_i,
  output logic            taken_o,
  output logic            annul_o,
  output logic            is_br_o,
  output logic [XLEN-1:0] target_o
);
  localparam int OFS_SHIFT = 2;

  function automatic logic kind_known(br_kind_t k);
    return (k == BK_EQZ) || (k == BK_NEZ) || (k == BK_EQZ_LK) || (k == BK_NEZ_LK);
  endfunction

  function automatic logic kind_likely(br_kind_t k);
    return (k == BK_EQZ_LK) || (k == BK_NEZ_LK);
  endfunction

  function automatic logic cond_met(br_kind_t k, logic [XLEN-1:0] v);
    logic is_zero;
    is_zero = (v == '0);
    case (k)
      BK_EQZ, BK_EQZ_LK: return is_zero;
      BK_NEZ, BK_NEZ_LK: return !is_zero;
      default:           return 1'b0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] branch_target(logic [XLEN-1:0] slot,
                                                     logic [XLEN-1:0] ofs);
    return slot + (ofs << OFS_SHIFT);
  endfunction

  logic cond_hit;

  always_comb begin
    cond_hit = cond_met(kind_i, rs_i);
    is_br_o  = valid_i && kind_known(kind_i);
    taken_o  = valid_i && cond_hit;
    annul_o  = valid_i && kind_likely(kind_i) && !cond_hit;
    target_o = branch_target(slot_pc_i, offset_i);
  end
endmodule

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int               XLEN     = 32,
  parameter logic [XLEN-1:0]  RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall_i,
  input  logic            redirect_i,
  input  logic [XLEN-1:0] target_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] next_pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] pc_d;

  always_comb begin
    seq_pc = pc_q + STEP;
    if (stall_i)         pc_d = pc_q;
    else if (redirect_i) pc_d = target_i;
    else                 pc_d = seq_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  assign pc_o      = pc_q;
  assign next_pc_o = pc_d;

  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> (pc_q == $past(pc_q)));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !redirect_i) |=> (pc_q == $past(pc_q) + STEP));

  // R5
  pc_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && redirect_i) |=> (pc_q == $past(target_i)));
endmodule

// File: rtl/ifid_reg.sv
module ifid_reg #(
  parameter int XLEN = 32,
  parameter int IW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall_i,
  input  logic            squash_i,
  input  logic            branch_in_dec_i,
  input  logic [XLEN-1:0] fetch_pc_i,
  input  logic [IW-1:0]   fetch_word_i,
  output logic            valid_o,
  output logic            slot_o,
  output logic [XLEN-1:0] pc_o,
  output logic [IW-1:0]   instr_o
);
  logic            valid_q;
  logic            slot_q;
  logic [XLEN-1:0] pc_q;
  logic [IW-1:0]   instr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      slot_q  <= 1'b0;
      pc_q    <= '0;
      instr_q <= '0;
    end else if (!stall_i) begin
      valid_q <= !squash_i;
      slot_q  <= branch_in_dec_i;
      pc_q    <= fetch_pc_i;
      instr_q <= fetch_word_i;
    end
  end

  assign valid_o = valid_q;
  assign slot_o  = slot_q;
  assign pc_o    = pc_q;
  assign instr_o = instr_q;

  // R7
  slot_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && squash_i) |=> !valid_q);

  // R8
  ifid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(pc_q) && $stable(instr_q) && $stable(valid_q)));
endmodule

// File: rtl/fetch_redirect.sv
module fetch_redirect
  import fetch_redirect_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              IW       = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall_i,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [IW-1:0]   imem_data_i,
  output logic            id_valid_o,
  output logic [XLEN-1:0] id_pc_o,
  output logic [IW-1:0]   id_instr_o,
  input  logic [2:0]      dec_br_kind_i,
  input  logic [XLEN-1:0] dec_rs_i,
  input  logic [XLEN-1:0] dec_offset_i,
  input  logic            dec_reg_we_i,
  input  logic            dec_mem_we_i,
  output logic            id_reg_we_o,
  output logic            id_mem_we_o,
  output logic            redirect_o,
  output logic            squash_o,
  output logic [XLEN-1:0] next_pc_o
);
  logic [XLEN-1:0] fetch_pc;
  logic [XLEN-1:0] br_target;
  logic            br_taken;
  logic            br_annul;
  logic            br_present;
  logic            dec_valid;
  logic            dec_in_slot;

  br_resolve #(.XLEN(XLEN)) u_resolve (
    .valid_i   (dec_valid),
    .kind_i    (br_kind_t'(dec_br_kind_i)),
    .rs_i      (dec_rs_i),
    .offset_i  (dec_offset_i),
    .slot_pc_i (fetch_pc),
    .taken_o   (br_taken),
    .annul_o   (br_annul),
    .is_br_o   (br_present),
    .target_o  (br_target)
  );

  pc_unit #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall_i    (stall_i),
    .redirect_i (br_taken),
    .target_i   (br_target),
    .pc_o       (fetch_pc),
    .next_pc_o  (next_pc_o)
  );

  ifid_reg #(.XLEN(XLEN), .IW(IW)) u_ifid (
    .clk             (clk),
    .rst_n           (rst_n),
    .stall_i         (stall_i),
    .squash_i        (br_annul),
    .branch_in_dec_i (br_present),
    .fetch_pc_i      (fetch_pc),
    .fetch_word_i    (imem_data_i),
    .valid_o         (dec_valid),
    .slot_o          (dec_in_slot),
    .pc_o            (id_pc_o),
    .instr_o         (id_instr_o)
  );

  assign imem_addr_o = fetch_pc;
  assign id_valid_o  = dec_valid;
  assign id_reg_we_o = dec_valid && dec_reg_we_i;
  assign id_mem_we_o = dec_valid && dec_mem_we_i;
  assign redirect_o  = br_taken;
  assign squash_o    = br_annul;

  // R7
  redirect_squash_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect_o && squash_o));

  // R6
  slot_not_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_in_slot) |-> !br_present);

  // R9
  redirect_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> id_valid_o);
endmodule

// File: tb/fetch_redirect_test.sv
`timescale 1ns/1ps
module fetch_redirect_test;
  localparam int XLEN = 32;
  localparam int IW   = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            stall = 1'b0;
  logic [XLEN-1:0] imem_addr;
  logic [IW-1:0]   imem_data;
  logic            id_valid;
  logic [XLEN-1:0] id_pc;
  logic [IW-1:0]   id_instr;
  logic [2:0]      br_kind;
  logic [XLEN-1:0] br_rs;
  logic [XLEN-1:0] br_off;
  logic            reg_we;
  logic            mem_we;
  logic            id_reg_we;
  logic            id_mem_we;
  logic            redirect;
  logic            squash;
  logic [XLEN-1:0] next_pc;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // two programmable branch sites for the bench decoder
  logic [XLEN-1:0] a0_addr, a1_addr, a0_rs, a1_rs, a0_off, a1_off;
  logic [2:0]      a0_kind, a1_kind;

  always #4 clk = ~clk;

  function automatic logic [IW-1:0] word_at(logic [XLEN-1:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  assign imem_data = word_at(imem_addr);

  always_comb begin
    br_kind = 3'd0; br_rs = '0; br_off = '0;
    if (id_pc == a0_addr) begin
      br_kind = a0_kind; br_rs = a0_rs; br_off = a0_off;
    end else if (id_pc == a1_addr) begin
      br_kind = a1_kind; br_rs = a1_rs; br_off = a1_off;
    end
    reg_we = 1'b1;
    mem_we = id_pc[2];
  end

  fetch_redirect #(.XLEN(XLEN), .IW(IW)) uut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .id_valid_o(id_valid), .id_pc_o(id_pc), .id_instr_o(id_instr),
    .dec_br_kind_i(br_kind), .dec_rs_i(br_rs), .dec_offset_i(br_off),
    .dec_reg_we_i(reg_we), .dec_mem_we_i(mem_we),
    .id_reg_we_o(id_reg_we), .id_mem_we_o(id_mem_we),
    .redirect_o(redirect), .squash_o(squash), .next_pc_o(next_pc)
  );

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    stall = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 fetch addr", imem_addr, 32'h0);
    chk("R1 id_valid", {31'b0, id_valid}, 32'h0);
    chk("R1 redirect", {31'b0, redirect}, 32'h0);
    chk("R1 squash", {31'b0, squash}, 32'h0);
    rst_n = 1'b1;
  endtask

  // one branch at address b; results checked around it
  task automatic run_branch(string tag, logic [XLEN-1:0] b, logic [2:0] kind,
                            logic [XLEN-1:0] rs, logic [XLEN-1:0] off,
                            bit exp_taken, bit exp_annul);
    logic [XLEN-1:0] tgt, nxt;
    tgt = (b + 32'd4) + (off << 2);
    nxt = exp_taken ? tgt : b + 32'd8;
    a0_addr = b; a0_kind = kind; a0_rs = rs; a0_off = off;
    do_reset();
    for (int i = 0; i <= int'(b >> 2); i++) step();
    chk({tag, " R2 branch in decode"}, id_pc, b);
    chk({tag, " R2 slot fetched"}, imem_addr, b + 32'd4);
    chk({tag, " R4 redirect"}, {31'b0, redirect}, {31'b0, exp_taken});
    chk({tag, " R7 squash"}, {31'b0, squash}, {31'b0, exp_annul});
    step();
    chk({tag, " R6 slot pc"}, id_pc, b + 32'd4);
    chk({tag, " R6 slot valid"}, {31'b0, id_valid}, {31'b0, !exp_annul});
    chk({tag, " R7 slot reg_we"}, {31'b0, id_reg_we}, {31'b0, !exp_annul});
    chk({tag, " R5 next fetch"}, imem_addr, nxt);
    chk({tag, " R9 no redirect in slot"}, {31'b0, redirect}, 32'h0);
    step();
    chk({tag, " R5 after slot"}, id_pc, nxt);
    chk({tag, " R2 word"}, id_instr, word_at(nxt));
    chk({tag, " R2 seq fetch"}, imem_addr, nxt + 32'd4);
  endtask

  task automatic t_stall();
    logic [XLEN-1:0] b, tgt;
    b = 32'h10;
    tgt = (b + 32'd4) + (32'd6 << 2);
    a0_addr = b; a0_kind = 3'd1; a0_rs = 32'h0; a0_off = 32'd6;
    do_reset();
    for (int i = 0; i <= int'(b >> 2); i++) step();
    stall = 1'b1;
    step();
    step();
    chk("R8 pc frozen", imem_addr, b + 32'd4);
    chk("R8 decode frozen", id_pc, b);
    chk("R8 next_pc frozen", next_pc, b + 32'd4);
    chk("R8 redirect pending", {31'b0, redirect}, 32'h1);
    stall = 1'b0;
    step();
    chk("R8 slot after stall", id_pc, b + 32'd4);
    chk("R8 target after stall", imem_addr, tgt);
  endtask

  task automatic t_squashed_slot_fields();
    // likely not-taken at 0x18; the annulled slot carries a taken-looking branch
    a1_addr = 32'h1C; a1_kind = 3'd1; a1_rs = 32'h0; a1_off = 32'd5;
    run_branch("likely-nt fields", 32'h18, 3'd4, 32'h0, 32'd3, 1'b0, 1'b1);
    a1_addr = 32'hFFFF_FFF0;
  endtask

  task automatic t_mem_we_bubble();
    // slot at 0x1C has mem_we decoded as 1; squashed it must read 0
    a0_addr = 32'h18; a0_kind = 3'd3; a0_rs = 32'h9; a0_off = 32'd2;
    do_reset();
    for (int i = 0; i <= 6; i++) step();
    step();
    chk("R7 slot mem_we forced", {31'b0, id_mem_we}, 32'h0);
  endtask

  initial begin
    a0_addr = 32'hFFFF_FFF8; a1_addr = 32'hFFFF_FFF0;
    a0_kind = 0; a1_kind = 0; a0_rs = 0; a1_rs = 0; a0_off = 0; a1_off = 0;
    run_branch("eqz taken",       32'h10, 3'd1, 32'h0,  32'd4,          1'b1, 1'b0);
    run_branch("eqz not taken",   32'h10, 3'd1, 32'h5,  32'd4,          1'b0, 1'b0);
    run_branch("nez taken back",  32'h20, 3'd2, 32'h7,  32'hFFFF_FFFD,  1'b1, 1'b0);
    run_branch("nez not taken",   32'h20, 3'd2, 32'h0,  32'd8,          1'b0, 1'b0);
    run_branch("likely eqz nt",   32'h14, 3'd3, 32'h1,  32'd4,          1'b0, 1'b1);
    run_branch("likely nez tk",   32'h14, 3'd4, 32'h3,  32'd10,         1'b1, 1'b0);
    run_branch("R3 kind 6",       32'h0C, 3'd6, 32'h0,  32'd4,          1'b0, 1'b0);
    run_branch("R3 kind 5",       32'h0C, 3'd5, 32'h0,  32'd4,          1'b0, 1'b0);
    t_squashed_slot_fields();
    t_mem_we_bubble();
    t_stall();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule